// File: doc/BRIEF.md
# 10GBASE-KR Transceiver Bring-up Sequencer

This block powers up a 10GBASE-KR serial transceiver without software. After `start` it holds the transceiver's hardware reset low for a parameterised time. It then steps through a fixed program of Clause 45 register accesses, which it hands one at a time to an external MDIO master. The master sends each access on the wire and answers it with a single-cycle done pulse; for a read, the pulse carries the read data.

The program has five phases:
- **Configuration.** Soft reset, reference-clock selection, then auto-negotiation and link training turned off and on again, with a datapath reset after each change.
- **Restart.** Auto-negotiation is restarted and the restart register is read back to clear it.
- **Settle.** A fixed wait, derived from a clock-frequency parameter.
- **Status polling.** Four status registers are polled in a fixed order. Each is re-read until its masked value matches an expected pattern or a per-step timeout expires.
- **Clean-up.** Latched status and error counters are cleared by reading them. Per-lane low-speed status is cleared by writing to it.

A clean run ends in `ready`. A poll timeout ends in `fault`, with a code that names the poll step that failed. Either end state waits for the next `start`.

Top module: `kr_bringup_seq`

## Requirements
- R1: After `rst_n` is released, the block is idle with `hw_rst_n`=1, `req_valid`=0, `ready`=0, `fault`=0 and `fault_code`=0. A one-cycle `start` begins a run.
- R2: On `start`, `hw_rst_n` goes low for exactly CLK_HZ/1e6*RST_US cycles, and no request is made while it is low.
- R3: A request is presented with `req_valid`=1 and does not change until `rsp_done`. The cycle after `rsp_done`, `req_valid` is 0.
- R4: Requests use these encodings: `req_write`=1 for a write, `req_dev` is the 5-bit device address and `req_reg` is the 16-bit register address. After the hardware reset the first nine requests are writes, in this order:
  1. 0x8000 to 0x1E.0000
  2. REFCLK_SEL to 0x1E.001D
  3. 0x2000 to 0x07.0000
  4. 0x0000 to 0x01.0096
  5. 0x0008 to 0x1E.000E
  6. 0x3000 to 0x07.0000
  7. 0x0002 to 0x01.0096
  8. 0x0008 to 0x1E.000E
  9. 0x3200 to 0x07.0000
- R5: The restart write is followed by a read of 0x07.0000. From the done of that read, at least WAIT_CYC = CLK_HZ/1000*WAIT_MS cycles pass before the first poll request.
- R6: Four registers are polled in this order, each re-read until (data & mask) == value, and each is read exactly once more after its last mismatching read:
  - 0x1E.000F with mask 0x1803 and value 0x1803
  - 0x07.0001 with mask 0x0024 and value 0x0024
  - 0x01.0097 with mask 0x0005 and value 0x0001
  - 0x07.0030 with mask 0x0008 and value 0x0008
- R7: A link-training status read with bit 2 set (training in progress) does not pass, even when bit 0 is set.
- R8: A poll step that still mismatches after POLL_TO cycles enters a fault state. `fault` is 1 and `fault_code` is 1 to 4 for the first to fourth poll, and no further request is made until the next `start`.
- R9: After the polls, the block does the following in this order:
  1. Reads 0x1E.000F and 0x1E.0010.
  2. Reads 0x1E.0011+n for each lane n.
  3. Writes (n<<8)|0x0030 to 0x1E.000C for each lane n.
  4. Reads 0x1E.0015, 0x01.0001, 0x01.0008, 0x03.0001 and 0x03.0008.
- R10: After the last access, `ready` is 1 and no request follows. A `start` given while `ready` or `fault` is high begins a full new run, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a bring-up run |
| hw_rst_n | output | 1 | Hardware reset to the transceiver, active low |
| req_valid | output | 1 | Register access request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_dev | output | 5 | Clause 45 device address |
| req_reg | output | 16 | Register address |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Access finished (one cycle) |
| rsp_rdata | input | 16 | Read data, valid with `rsp_done` |
| ready | output | 1 | Bring-up completed |
| fault | output | 1 | Bring-up stopped on a poll timeout |
| fault_code | output | 4 | Failing poll step, 1 to 4 |

## Verification
The hardest behaviour to reach is a status register that answers many times with a pattern that almost matches. Examples are link-training status with bit 0 set but bit 2 still set, or a poll that never passes and has to run out its timeout partway through the program.

The bench models the transceiver's registers behind a responder with random latency. For each poll register it draws a random number of failing reads, each failing value differing from the expected pattern in one masked bit. It then checks the exact number of reads of every polled register. Directed runs make each of the four polls fail permanently in turn, then restart from the fault state and from the ready state.

// File: rtl/krb_pkg.sv
// Shared types for the KR bring-up sequencer.
// Assumes: step programs fit in 16-bit data and 5-bit device addresses.
package krb_pkg;

    // Kind of program step
    typedef enum logic [1:0] {
        K_WR   = 2'd0,
        K_RD   = 2'd1,
        K_POLL = 2'd2,
        K_WAIT = 2'd3
    } op_t;

    // One program step; for polls data is the mask and want the pattern
    typedef struct packed {
        op_t         kind;
        logic [4:0]  dev;
        logic [15:0] regad;
        logic [15:0] data;
        logic [15:0] want;
        logic [3:0]  code;
    } step_t;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HWRST = 3'd1,
        S_LOAD  = 3'd2,
        S_ISSUE = 3'd3,
        S_GAP   = 3'd4,
        S_WAIT  = 3'd5,
        S_DONE  = 3'd6,
        S_FAULT = 3'd7
    } st_t;

endpackage

// File: rtl/krb_timer.sv
// Down-counter shared by the reset hold, settle wait and poll timeout.
// Assumes: load has priority; counter saturates at zero.
module krb_timer #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load a new period or count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/krb_step_rom.sv
// Computed program of the bring-up: maps a step index to an access.
// Assumes: LANES >= 1; indices at or beyond the program end are never used.
module krb_step_rom
    import krb_pkg::*;
#(
    parameter int          LANES      = 4,
    parameter int          SW         = 6,
    parameter logic [15:0] REFCLK_SEL = 16'h0000
) (
    input  logic [SW-1:0] idx,
    output step_t         ent
);
    localparam int ERR0  = 17;
    localparam int WRL0  = ERR0 + LANES;
    localparam int TAIL0 = WRL0 + LANES;

    int i;

    // Decode the step index into kind, address, data and poll pattern
    always_comb begin
        ent = '{kind: K_RD, dev: 5'h1E, regad: 16'h0000, data: 16'h0000,
                want: 16'h0000, code: 4'h0};
        i = int'(idx);
        if (i < ERR0) begin
            case (i)
                0:  ent = '{K_WR,   5'h1E, 16'h0000, 16'h8000,   16'h0, 4'h0};
                1:  ent = '{K_WR,   5'h1E, 16'h001D, REFCLK_SEL, 16'h0, 4'h0};
                2:  ent = '{K_WR,   5'h07, 16'h0000, 16'h2000,   16'h0, 4'h0};
                3:  ent = '{K_WR,   5'h01, 16'h0096, 16'h0000,   16'h0, 4'h0};
                4:  ent = '{K_WR,   5'h1E, 16'h000E, 16'h0008,   16'h0, 4'h0};
                5:  ent = '{K_WR,   5'h07, 16'h0000, 16'h3000,   16'h0, 4'h0};
                6:  ent = '{K_WR,   5'h01, 16'h0096, 16'h0002,   16'h0, 4'h0};
                7:  ent = '{K_WR,   5'h1E, 16'h000E, 16'h0008,   16'h0, 4'h0};
                8:  ent = '{K_WR,   5'h07, 16'h0000, 16'h3200,   16'h0, 4'h0};
                9:  ent = '{K_RD,   5'h07, 16'h0000, 16'h0000,   16'h0, 4'h0};
                10: ent = '{K_WAIT, 5'h00, 16'h0000, 16'h0000,   16'h0, 4'h0};
                11: ent = '{K_POLL, 5'h1E, 16'h000F, 16'h1803, 16'h1803, 4'h1};
                12: ent = '{K_POLL, 5'h07, 16'h0001, 16'h0024, 16'h0024, 4'h2};
                13: ent = '{K_POLL, 5'h01, 16'h0097, 16'h0005, 16'h0001, 4'h3};
                14: ent = '{K_POLL, 5'h07, 16'h0030, 16'h0008, 16'h0008, 4'h4};
                15: ent = '{K_RD,   5'h1E, 16'h000F, 16'h0000,   16'h0, 4'h0};
                default: ent = '{K_RD, 5'h1E, 16'h0010, 16'h0000, 16'h0, 4'h0};
            endcase
        end else if (i < WRL0) begin
            ent.kind  = K_RD;
            ent.regad = 16'(32'h11 + (i - ERR0));
        end else if (i < TAIL0) begin
            ent.kind  = K_WR;
            ent.regad = 16'h000C;
            ent.data  = 16'(((i - WRL0) << 8) | 32'h30);
        end else begin
            case (i - TAIL0)
                0:       ent = '{K_RD, 5'h1E, 16'h0015, 16'h0, 16'h0, 4'h0};
                1:       ent = '{K_RD, 5'h01, 16'h0001, 16'h0, 16'h0, 4'h0};
                2:       ent = '{K_RD, 5'h01, 16'h0008, 16'h0, 16'h0, 4'h0};
                3:       ent = '{K_RD, 5'h03, 16'h0001, 16'h0, 16'h0, 4'h0};
                default: ent = '{K_RD, 5'h03, 16'h0008, 16'h0, 16'h0, 4'h0};
            endcase
        end
    end
endmodule

// File: rtl/kr_bringup_seq.sv
// Top of the KR bring-up sequencer: hardware reset, register program,
// settle wait, masked status polls with timeout, latched-status clean-up.
// Assumes: the MDIO master answers every request with one rsp_done pulse.
module kr_bringup_seq
    import krb_pkg::*;
#(
    parameter int          CLK_HZ     = 125_000_000,
    parameter int          RST_US     = 10,
    parameter int          WAIT_MS    = 1000,
    parameter int          POLL_TO    = 1_000_000,
    parameter int          LANES      = 4,
    parameter logic [15:0] REFCLK_SEL = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        hw_rst_n,
    output logic        req_valid,
    output logic        req_write,
    output logic [4:0]  req_dev,
    output logic [15:0] req_reg,
    output logic [15:0] req_wdata,
    input  logic        rsp_done,
    input  logic [15:0] rsp_rdata,
    output logic        ready,
    output logic        fault,
    output logic [3:0]  fault_code
);
    localparam int NSTEPS   = 22 + 2 * LANES;
    localparam int SW       = $clog2(NSTEPS + 1);
    localparam int CW       = 32;
    localparam int RST_CYC  = CLK_HZ / 1_000_000 * RST_US;
    localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;
    localparam logic [CW-1:0] RST_LOAD  = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] WAIT_LOAD = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0] POLL_LOAD = CW'(POLL_TO);
    localparam logic [SW-1:0] LAST_IDX  = SW'(NSTEPS);

    st_t           st, st_n;
    logic [SW-1:0] step, step_n;
    logic          adv, adv_n;
    logic [3:0]    code, code_n;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    step_t         ent;
    logic          hit;

    krb_step_rom #(.LANES(LANES), .SW(SW), .REFCLK_SEL(REFCLK_SEL)) u_rom (
        .idx (step),
        .ent (ent)
    );

    krb_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Masked comparison of the returned poll data
    assign hit = ((rsp_rdata & ent.data) == ent.want);

    // Next-state, step advance and timer load decisions
    always_comb begin
        st_n     = st;
        step_n   = step;
        adv_n    = adv;
        code_n   = code;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_IDLE, S_DONE, S_FAULT: begin
                if (start) begin
                    st_n     = S_HWRST;
                    step_n   = '0;
                    code_n   = 4'h0;
                    tmr_load = 1'b1;
                    tmr_val  = RST_LOAD;
                end
            end
            S_HWRST: if (tmr_zero) st_n = S_LOAD;
            S_LOAD: begin
                if (step == LAST_IDX) begin
                    st_n = S_DONE;
                end else if (ent.kind == K_WAIT) begin
                    st_n     = S_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LOAD;
                end else begin
                    st_n = S_ISSUE;
                    if (ent.kind == K_POLL) begin
                        tmr_load = 1'b1;
                        tmr_val  = POLL_LOAD;
                    end
                end
            end
            S_ISSUE: begin
                if (rsp_done) begin
                    if (ent.kind != K_POLL || hit) begin
                        adv_n = 1'b1;
                        st_n  = S_GAP;
                    end else if (tmr_zero) begin
                        code_n = ent.code;
                        st_n   = S_FAULT;
                    end else begin
                        adv_n = 1'b0;
                        st_n  = S_GAP;
                    end
                end
            end
            S_WAIT: begin
                if (tmr_zero) begin
                    adv_n = 1'b1;
                    st_n  = S_GAP;
                end
            end
            S_GAP: begin
                if (adv) begin
                    step_n = step + 1'b1;
                    st_n   = S_LOAD;
                end else begin
                    st_n = S_ISSUE;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    // State, step pointer, retry flag and fault code registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            step <= '0;
            adv  <= 1'b0;
            code <= 4'h0;
        end else begin
            st   <= st_n;
            step <= step_n;
            adv  <= adv_n;
            code <= code_n;
        end
    end

    // Output decode from the registered state and current step
    always_comb begin
        hw_rst_n   = (st != S_HWRST);
        req_valid  = (st == S_ISSUE);
        req_write  = (ent.kind == K_WR);
        req_dev    = ent.dev;
        req_reg    = ent.regad;
        req_wdata  = ent.data;
        ready      = (st == S_DONE);
        fault      = (st == S_FAULT);
        fault_code = code;
    end
endmodule

// File: rtl/kr_bringup_seq_chk.sv
// Protocol checker for kr_bringup_seq, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module kr_bringup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        hw_rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [4:0]  req_dev,
    input logic [15:0] req_reg,
    input logic [15:0] req_wdata,
    input logic        rsp_done,
    input logic        ready,
    input logic        fault,
    input logic [3:0]  fault_code
);
    a_r2_no_req_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |-> !req_valid);

    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_done |=> req_valid && $stable(req_write) && $stable(req_dev)
                                   && $stable(req_reg) && $stable(req_wdata));

    a_r3_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_done |=> !req_valid);

    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !start |=> fault && !req_valid);

    a_r8_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 4'h0 && fault_code <= 4'h4));

    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !req_valid && !fault);

    a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> hw_rst_n);
endmodule

bind kr_bringup_seq kr_bringup_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .hw_rst_n   (hw_rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_dev    (req_dev),
    .req_reg    (req_reg),
    .req_wdata  (req_wdata),
    .rsp_done   (rsp_done),
    .ready      (ready),
    .fault      (fault),
    .fault_code (fault_code)
);

// File: tb/tb_kr_bringup_seq.sv
// Self-checking bench: register-model responder with random latency,
// random failing-read counts per poll, directed fault and restart runs.
module tb_kr_bringup_seq;
    localparam int CLK_HZ   = 1_000_000;   // scaled so waits stay short
    localparam int RST_US   = 10;
    localparam int WAIT_MS  = 2;
    localparam int POLL_TO  = 400;
    localparam int LANES    = 4;
    localparam int RST_CYC  = CLK_HZ / 1_000_000 * RST_US;
    localparam int WAIT_CYC = CLK_HZ / 1000 * WAIT_MS;
    localparam int NSTEPS   = 22 + 2 * LANES;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hw_rst_n, req_valid, req_write, ready, fault;
    logic [4:0]  req_dev;
    logic [15:0] req_reg, req_wdata, rsp_rdata;
    logic        rsp_done = 1'b0;
    logic [3:0]  fault_code;

    kr_bringup_seq #(.CLK_HZ(CLK_HZ), .RST_US(RST_US), .WAIT_MS(WAIT_MS),
                     .POLL_TO(POLL_TO), .LANES(LANES), .REFCLK_SEL(16'h0000)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hw_rst_n(hw_rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
        .req_reg(req_reg), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .ready(ready), .fault(fault), .fault_code(fault_code)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int nlog = 0, hw_low = 0, viol = 0, t_rd = -1, t_poll = -1;
    logic [37:0] logv [256];
    int good_after [4];
    int preads [4];
    logic [15:0] badv [4], goodv [4];
    logic [15:0] pmask [4] = '{16'h1803, 16'h0024, 16'h0005, 16'h0008};
    logic [15:0] pwant [4] = '{16'h1803, 16'h0024, 16'h0001, 16'h0008};
    logic [15:0] pflip [4] = '{16'h0800, 16'h0020, 16'h0004, 16'h0008};
    logic [4:0]  pdev  [4] = '{5'h1E, 5'h07, 5'h01, 5'h07};
    logic [15:0] preg  [4] = '{16'h000F, 16'h0001, 16'h0097, 16'h0030};
    logic        prev_v = 1'b0, prev_d = 1'b0;
    logic [37:0] prev_f = '0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // Expected program entry {write, dev, reg, wdata}, computed from R4/R5/R6/R9
    function automatic logic [37:0] exp_tx(input int i);
        case (i)
            0:  return {1'b1, 5'h1E, 16'h0000, 16'h8000};
            1:  return {1'b1, 5'h1E, 16'h001D, 16'h0000};
            2:  return {1'b1, 5'h07, 16'h0000, 16'h2000};
            3:  return {1'b1, 5'h01, 16'h0096, 16'h0000};
            4:  return {1'b1, 5'h1E, 16'h000E, 16'h0008};
            5:  return {1'b1, 5'h07, 16'h0000, 16'h3000};
            6:  return {1'b1, 5'h01, 16'h0096, 16'h0002};
            7:  return {1'b1, 5'h1E, 16'h000E, 16'h0008};
            8:  return {1'b1, 5'h07, 16'h0000, 16'h3200};
            9:  return {1'b0, 5'h07, 16'h0000, 16'h0000};
            11: return {1'b0, 5'h1E, 16'h000F, 16'h0000};
            12: return {1'b0, 5'h07, 16'h0001, 16'h0000};
            13: return {1'b0, 5'h01, 16'h0097, 16'h0000};
            14: return {1'b0, 5'h07, 16'h0030, 16'h0000};
            15: return {1'b0, 5'h1E, 16'h000F, 16'h0000};
            16: return {1'b0, 5'h1E, 16'h0010, 16'h0000};
            17: return {1'b0, 5'h1E, 16'h0011, 16'h0000};
            18: return {1'b0, 5'h1E, 16'h0012, 16'h0000};
            19: return {1'b0, 5'h1E, 16'h0013, 16'h0000};
            20: return {1'b0, 5'h1E, 16'h0014, 16'h0000};
            21: return {1'b1, 5'h1E, 16'h000C, 16'h0030};
            22: return {1'b1, 5'h1E, 16'h000C, 16'h0130};
            23: return {1'b1, 5'h1E, 16'h000C, 16'h0230};
            24: return {1'b1, 5'h1E, 16'h000C, 16'h0330};
            25: return {1'b0, 5'h1E, 16'h0015, 16'h0000};
            26: return {1'b0, 5'h01, 16'h0001, 16'h0000};
            27: return {1'b0, 5'h01, 16'h0008, 16'h0000};
            28: return {1'b0, 5'h03, 16'h0001, 16'h0000};
            default: return {1'b0, 5'h03, 16'h0008, 16'h0000};
        endcase
    endfunction

    function automatic string tag_of(input int i);
        if (i <= 8) return "R4";
        if (i == 9) return "R5";
        if (i == 13) return "R7";
        if (i >= 11 && i <= 14) return "R6";
        return "R9";
    endfunction

    // Responder: random latency, poll-register model, transaction log
    initial begin
        rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (req_valid) begin
                logic [15:0] rd;
                repeat ($urandom % 4) @(negedge clk);
                rd = 16'($urandom);
                for (int k = 0; k < 4; k++) begin
                    if (!req_write && req_dev == pdev[k] && req_reg == preg[k]
                        && t_poll >= 0 && preads[k] <= good_after[k] && nlog >= 10) begin
                        rd = (preads[k] < good_after[k]) ? badv[k] : goodv[k];
                        preads[k]++;
                    end
                end
                if (nlog < 256)
                    logv[nlog] = {req_write, req_dev, req_reg, req_write ? req_wdata : 16'h0};
                nlog++;
                rsp_rdata = rd;
                rsp_done  = 1'b1;
                @(negedge clk);
                rsp_done  = 1'b0;
            end
        end
    end

    // Monitor: reset-low length, handshake rules, settle-wait gap
    always @(negedge clk) begin
        if (rst_n) begin
            if (!hw_rst_n) hw_low++;
            if (!hw_rst_n && req_valid) viol++;
            if (prev_v && !prev_d &&
                !(req_valid && {req_write, req_dev, req_reg, req_wdata} == prev_f)) viol++;
            if (prev_d && prev_v && req_valid) viol++;
            if (rsp_done && req_valid && !req_write && req_dev == 5'h07 && req_reg == 16'h0)
                t_rd = cyc;
            if (req_valid && !prev_v && req_dev == 5'h1E && req_reg == 16'h000F
                && t_rd >= 0 && t_poll < 0)
                t_poll = cyc;
        end
        prev_v = req_valid;
        prev_d = rsp_done;
        prev_f = {req_write, req_dev, req_reg, req_wdata};
    end

    // Cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog: actual %0d cycles expected < %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // One bring-up run; fk = poll index forced to fail, -1 for none
    task automatic run(input int fk, input bit directed_zero);
        int k_exp;
        int waited;
        for (int k = 0; k < 4; k++) begin
            good_after[k] = (k == fk) ? 100000 : (directed_zero ? 0 : int'($urandom % 6));
            goodv[k] = (16'($urandom) & ~pmask[k]) | pwant[k];
            badv[k]  = (16'($urandom) & ~pmask[k]) | (pwant[k] ^ pflip[k]);
            preads[k] = 0;
        end
        nlog = 0; hw_low = 0; viol = 0; t_rd = -1; t_poll = -1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        waited = 0;
        while (!ready && !fault && waited < 30000) begin
            @(negedge clk); waited++;
        end
        check(hw_low == RST_CYC, "R2", "hw reset low cycles", hw_low, RST_CYC);
        check(viol == 0, "R3", "handshake violations", viol, 0);
        if (fk < 0) begin
            check(ready == 1'b1 && fault == 1'b0, "R10", "ready/fault", {ready, fault}, 2'b10);
            check(t_poll - t_rd >= WAIT_CYC && t_poll - t_rd <= WAIT_CYC + 8, "R5",
                  "settle gap", t_poll - t_rd, WAIT_CYC);
            for (int k = 0; k < 4; k++)
                check(preads[k] == good_after[k] + 1, (k == 2) ? "R7" : "R6",
                      "poll read count", preads[k], good_after[k] + 1);
            k_exp = 0;
            for (int i = 0; i < NSTEPS; i++) begin
                if (i != 10) begin
                    int reps = (i >= 11 && i <= 14) ? good_after[i - 11] + 1 : 1;
                    for (int r = 0; r < reps; r++) begin
                        if (k_exp < 256 && k_exp < nlog)
                            check(logv[k_exp] == exp_tx(i), tag_of(i), "access",
                                  int'(logv[k_exp][31:0]), int'(exp_tx(i) & 38'hFFFFFFFF));
                        k_exp++;
                    end
                end
            end
            check(nlog == k_exp, "R9", "access count", nlog, k_exp);
            repeat (100) @(negedge clk);
            check(nlog == k_exp && ready, "R10", "quiet after ready", nlog, k_exp);
        end else begin
            check(fault == 1'b1 && ready == 1'b0, "R8", "fault/ready", {fault, ready}, 2'b10);
            check(int'(fault_code) == fk + 1, "R8", "fault code", int'(fault_code), fk + 1);
            check(nlog > 0 && nlog <= 256 && logv[nlog-1][36:16] == {pdev[fk], preg[fk]},
                  "R8", "last access reg", int'(logv[(nlog > 0 && nlog <= 256) ? nlog-1 : 0][31:16]),
                  int'(preg[fk]));
            k_exp = nlog;
            repeat (300) @(negedge clk);
            check(nlog == k_exp && fault, "R8", "no access after fault", nlog, k_exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hw_rst_n == 1'b1, "R1", "hw_rst_n after reset", hw_rst_n, 1);
        check(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
        check(ready == 1'b0 && fault == 1'b0, "R1", "ready/fault after reset",
              {ready, fault}, 0);
        check(fault_code == 4'h0, "R1", "fault_code after reset", fault_code, 0);
        repeat (20) @(negedge clk);
        check(req_valid == 1'b0 && hw_rst_n, "R1", "idle without start", req_valid, 0);
        run(-1, 1'b1);               // directed: every poll passes at once
        run(-1, 1'b0);               // random failing-read counts
        run(-1, 1'b0);               // R10 restart from ready
        for (int k = 0; k < 4; k++) run(k, 1'b0);   // R8 each poll times out
        run(-1, 1'b0);               // R10 restart from fault
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule